// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block models the read data path of a single-data-rate synchronous DRAM device. A mode word, written through a load strobe, sets three things: how many words a read returns, whether the column address walks upward with wrap-around or is XOR-scrambled with the beat number, and how many clock edges pass between the READ and its first data word. A decoded READ arrives with a starting column address. After the programmed latency the block drives the burst of words, read from an internal column array, onto its data bus.

The output-enable goes high one edge before the first valid word, so a real pad would leave high impedance early. It drops on the edge after the last word. A READ issued while an earlier burst is still in flight cuts that burst off. The earlier data keeps flowing until the new READ's first word is due, and the new data then takes over. A mode word with a reserved encoding raises an error flag, and any READ issued under that mode is dropped.

Top module: `sdram_read_seq`

## Requirements
- R1: While reset is low, dqOe, dqValid and dqData are all zero and modeErr is low. The mode register resets to latency 2, sequential order and burst length 1 (value 7'b010_0_000).
- R2: Mode word fields are as follows. Bits [2:0] set the burst length: 000 is 1, 001 is 2, 010 is 4 and 011 is 8. Bit 3 selects the order: 0 is sequential, 1 is interleaved. Bits [6:4] set the latency: 010 is 2, 011 is 3. A word loaded on an edge applies to READs registered on later edges. A READ registered on the same edge as the load still uses the old mode.
- R3: For a READ registered at edge n with latency m, the first burst word is on dqData with dqValid high after edge n+m.
- R4: dqOe rises after edge n+m-1, one edge before the first word. In that lead cycle dqValid is low and dqData is zero, unless an earlier burst is still delivering words.
- R5: A burst delivers exactly its length of words on consecutive edges. On the edge after the last word, dqOe and dqValid fall and dqData returns to zero, unless another burst is due.
- R6: In sequential order, the column bits below the burst length count upward from the starting column and wrap: low = (start + i) mod BL.
- R7: In interleaved order, the low column bits are the starting bits XORed with the beat index: low = start XOR i.
- R8: modeErr is high whenever the stored mode has a reserved burst-length code (1xx) or a latency code other than 010 and 011. A READ issued while modeErr is high starts no burst and does not disturb one already in flight.
- R9: A new READ cuts off any earlier burst. The earlier words continue up to edge n+m-1 of the new READ, and the new READ's words start at its own edge n+m. If both first words fall on the same edge, the newer READ wins.
- R10: The word for column c has bit i equal to c[i mod COL_W], inverted when (i / COL_W) is odd. With the defaults this is {~c, c}. Column bits at and above the burst length stay at the starting column's value for the whole burst.
- R11: Burst length, order and latency are captured when the READ is registered. A mode load after the READ does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | Strobe that writes modeWord into the mode register |
| modeWord | input | 7 | Mode word: length [2:0], order [3], latency [6:4] |
| readCmd | input | 1 | Decoded READ command, registered on the rising edge |
| readCol | input | COL_W | Starting column address of the READ |
| dqData | output | DW | Read data bus, zero whenever no word is valid |
| dqOe | output | 1 | Output-enable for the data drivers |
| dqValid | output | 1 | High in cycles where dqData carries a burst word |
| modeErr | output | 1 | Stored mode word holds a reserved encoding |

## Verification
The embedded properties check on every cycle that a valid word always comes with the output-enable, that the enable never rises in the same cycle as a word, and that it only falls right after a delivered word. They also check that the beat counter stays within the captured burst length, that the captured length is a power of two, and that a READ under a reserved mode leaves the latency pipeline empty. Only the bench's scenarios can show the exact edge of the first word for each latency, the column order for sequential and interleaved bursts from different start points, and the hand-over when a READ cuts off a burst, including two reads that would land on the same edge. The same holds for capture of the mode at command time while the mode register changes underneath a burst.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  localparam int MODE_W = 7;
  localparam int MAX_CL = 3;
  localparam int MAX_BL = 8;
  localparam int OFS_W  = $clog2(MAX_BL);
  localparam logic [MODE_W-1:0] MODE_RESET = 7'b010_0_000;

  // Decoded view of the mode register
  typedef struct packed {
    logic             ok;
    logic [OFS_W:0]   len;
    logic [OFS_W-1:0] mask;
    logic             ilv;
    logic [1:0]       cl;
  } modeDec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             emit;
    logic             oe;
    logic             ilv;
    logic [OFS_W-1:0] mask;
    logic [OFS_W-1:0] offset;
  } pathCtl_t;

  function automatic modeDec_t decodeMode(input logic [MODE_W-1:0] m);
    modeDec_t d;
    logic     blOk;
    logic     clOk;
    d    = '0;
    blOk = 1'b1;
    clOk = 1'b1;
    d.ilv = m[3];
    case (m[2:0])
      3'b000:  begin d.len = 4'd1; d.mask = 3'd0; end
      3'b001:  begin d.len = 4'd2; d.mask = 3'd1; end
      3'b010:  begin d.len = 4'd4; d.mask = 3'd3; end
      3'b011:  begin d.len = 4'd8; d.mask = 3'd7; end
      default: blOk = 1'b0;
    endcase
    case (m[6:4])
      3'b010:  d.cl = 2'd2;
      3'b011:  d.cl = 2'd3;
      default: clOk = 1'b0;
    endcase
    d.ok = blOk && clOk;
    return d;
  endfunction

endpackage

// File: rtl/sdrd_ctrl.sv
module sdrd_ctrl
  import sdrd_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              readCmd,
  input  logic [COL_W-1:0]  readCol,
  output logic              modeErr,
  output pathCtl_t          ctl,
  output logic [COL_W-1:0]  colBase
);

  localparam int SLOTS = MAX_CL;

  typedef struct packed {
    logic             v;
    logic [COL_W-1:0] col;
    logic [OFS_W:0]   len;
    logic [OFS_W-1:0] mask;
    logic             ilv;
  } slot_t;

  logic [MODE_W-1:0] modeQ;
  modeDec_t          dec;
  logic              accept;
  slot_t             newSlot;
  slot_t             pipeQ [SLOTS];
  slot_t             curQ;
  logic              active;
  logic [OFS_W:0]    idx;
  logic              launch;
  logic              lastDone;

  // Mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeQ <= MODE_RESET;
    else if (modeLoad) modeQ <= modeWord;
  end

  assign dec     = decodeMode(modeQ);
  assign modeErr = !dec.ok;
  assign accept  = readCmd && dec.ok;

  always_comb begin
    newSlot      = '0;
    newSlot.v    = 1'b1;
    newSlot.col  = readCol;
    newSlot.len  = dec.len;
    newSlot.mask = dec.mask;
    newSlot.ilv  = dec.ilv;
  end

  // Latency pipeline: a READ enters at slot (latency-1), launches from slot 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SLOTS; k++) pipeQ[k] <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (accept && (int'(dec.cl) - 1 == k)) pipeQ[k] <= newSlot;
        else if (k == SLOTS - 1)               pipeQ[k] <= '0;
        else                                   pipeQ[k] <= pipeQ[k+1];
      end
    end
  end

  assign launch   = pipeQ[0].v;
  assign lastDone = active && (idx == curQ.len);

  // Burst engine: a launch always replaces the burst in progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      idx    <= '0;
      curQ   <= '0;
    end else if (launch) begin
      active <= 1'b1;
      idx    <= 1;
      curQ   <= pipeQ[0];
    end else if (lastDone) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
    end
  end

  // Strobes to datapath
  always_comb begin
    ctl = '0;
    if (launch) begin
      ctl.emit   = 1'b1;
      ctl.ilv    = pipeQ[0].ilv;
      ctl.mask   = pipeQ[0].mask;
      ctl.offset = '0;
      colBase    = pipeQ[0].col;
    end else begin
      ctl.emit   = active && !lastDone;
      ctl.ilv    = curQ.ilv;
      ctl.mask   = curQ.mask;
      ctl.offset = idx[OFS_W-1:0];
      colBase    = curQ.col;
    end
    ctl.oe = ctl.emit || pipeQ[1].v;
  end

  // R8: READ under reserved mode leaves an empty pipeline empty
  assert_rd_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (readCmd && modeErr && !pipeQ[1].v && !pipeQ[2].v)
      |=> (!pipeQ[0].v && !pipeQ[1].v && !pipeQ[2].v))
    else $error("reserved-mode READ entered the latency pipeline");

  // R3: an accepted READ is held in the pipeline for at least one more edge
  assert_rd_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (pipeQ[1].v || pipeQ[2].v))
    else $error("accepted READ missing from latency pipeline");

  // R5: beat counter bounded by captured burst length
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (idx != 0 && idx <= curQ.len))
    else $error("beat counter outside burst");

  // R2: captured burst length is one of 1, 2, 4, 8
  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    active |-> ($countones(curQ.len) == 1))
    else $error("captured burst length not a power of two");

endmodule

// File: rtl/sdrd_path.sv
module sdrd_path
  import sdrd_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  logic [COL_W-1:0] colBase,
  output logic [DW-1:0]    dqData,
  output logic             dqOe,
  output logic             dqValid
);

  localparam int LOW_W = OFS_W;
  localparam int PAD_W = COL_W - LOW_W;

  logic [LOW_W-1:0] startLow;
  logic [LOW_W-1:0] seqLow;
  logic [LOW_W-1:0] ilvLow;
  logic [LOW_W-1:0] pickLow;
  logic [COL_W-1:0] keepMask;
  logic [COL_W-1:0] colAddr;
  logic [DW-1:0]    word;

  // Column ordering within the burst
  assign startLow = colBase[LOW_W-1:0];
  assign seqLow   = (startLow + ctl.offset) & ctl.mask;
  assign ilvLow   = (startLow ^ ctl.offset) & ctl.mask;
  assign pickLow  = ctl.ilv ? ilvLow : seqLow;
  assign keepMask = ~{{PAD_W{1'b0}}, ctl.mask};
  assign colAddr  = (colBase & keepMask) | {{PAD_W{1'b0}}, pickLow};

  // Column array contents: a fixed function of the column address
  generate
    for (genvar i = 0; i < DW; i++) begin : g_word
      assign word[i] = colAddr[i % COL_W] ^ 1'((i / COL_W) % 2);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqData  <= '0;
      dqOe    <= 1'b0;
      dqValid <= 1'b0;
    end else begin
      dqData  <= ctl.emit ? word : '0;
      dqOe    <= ctl.oe;
      dqValid <= ctl.emit;
    end
  end

  // R4: a word never appears without the enable
  assert_valid_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    dqValid |-> dqOe)
    else $error("valid word without output enable");

  // R4: the enable rises one cycle ahead of data
  assert_lead_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dqOe) |-> !dqValid)
    else $error("enable rose together with data");

  // R5: the enable only falls right after a delivered word
  assert_tail_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqOe) |-> $past(dqValid))
    else $error("enable fell without a preceding word");

endmodule

// File: rtl/sdram_read_seq.sv
module sdram_read_seq
  import sdrd_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              readCmd,
  input  logic [COL_W-1:0]  readCol,
  output logic [DW-1:0]     dqData,
  output logic              dqOe,
  output logic              dqValid,
  output logic              modeErr
);

  pathCtl_t         ctl;
  logic [COL_W-1:0] colBase;

  sdrd_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeLoad (modeLoad),
    .modeWord (modeWord),
    .readCmd  (readCmd),
    .readCol  (readCol),
    .modeErr  (modeErr),
    .ctl      (ctl),
    .colBase  (colBase)
  );

  sdrd_path #(.COL_W(COL_W), .DW(DW)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .colBase (colBase),
    .dqData  (dqData),
    .dqOe    (dqOe),
    .dqValid (dqValid)
  );

endmodule

// File: tb/sim_sdram_read_seq.sv
module sim_sdram_read_seq;

  localparam int HORIZON = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [6:0]  modeWord = '0;
  logic        readCmd = 1'b0;
  logic [7:0]  readCol = '0;
  logic [15:0] dqData;
  logic        dqOe;
  logic        dqValid;
  logic        modeErr;

  sdram_read_seq u0 (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .readCmd(readCmd), .readCol(readCol), .dqData(dqData), .dqOe(dqOe),
    .dqValid(dqValid), .modeErr(modeErr)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    wd = 0;
  bit    running = 0;
  string scen = "R2";
  logic [6:0]  benchMode = 7'b010_0_000;
  bit          expOe    [HORIZON];
  bit          expValid [HORIZON];
  logic [15:0] expData  [HORIZON];
  string       expTag   [HORIZON];

  function automatic bit modeBad(input logic [6:0] m);
    return (m[2:0] > 3'd3) || !(m[6:4] == 3'd2 || m[6:4] == 3'd3);
  endfunction

  function automatic logic [15:0] wordAt(input int a);
    logic [7:0] c;
    c = a[7:0];
    return {~c, c};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at edge %0d: got %0h expected %0h", tag, what, cyc, got, exp);
    end
  endtask

  // Behavioural timeline of expected outputs per edge
  task automatic schedule(input int n, input logic [6:0] m, input logic [7:0] col);
    int cl, bl, start, base, low, c;
    bit ilv;
    cl    = int'(m[6:4]);
    bl    = 1 << m[2:0];
    ilv   = m[3];
    start = int'(col) % bl;
    base  = int'(col) - start;
    for (int k = n + cl; k < n + cl + 12 && k < HORIZON; k++) begin
      expOe[k] = 0; expValid[k] = 0; expData[k] = '0; expTag[k] = "idle";
    end
    expOe[n+cl-1] = 1;
    if (!expValid[n+cl-1]) expTag[n+cl-1] = {scen, " R4 lead"};
    for (int i = 0; i < bl; i++) begin
      c   = n + cl + i;
      low = ilv ? (start ^ i) : ((start + i) % bl);
      expOe[c]    = 1;
      expValid[c] = 1;
      expData[c]  = wordAt(base + low);
      expTag[c]   = {scen, (i == 0) ? " R3 first" : (ilv ? " R7 ilv" : " R6 seq"), " R10"};
    end
    expTag[n+cl+bl] = {scen, " R5 tail"};
  endtask

  initial begin
    for (int k = 0; k < HORIZON; k++) begin
      expOe[k] = 0; expValid[k] = 0; expData[k] = '0; expTag[k] = "idle";
    end
  end

  always @(posedge clk) begin
    if (running) begin
      cyc++;
      if (readCmd && !modeBad(benchMode)) schedule(cyc, benchMode, readCol);
      if (modeLoad) benchMode = modeWord;
    end
  end

  always @(negedge clk) begin
    if (running && cyc > 0 && cyc < HORIZON) begin
      check(dqOe == expOe[cyc], expTag[cyc], "dqOe", int'(dqOe), int'(expOe[cyc]));
      check(dqValid == expValid[cyc], expTag[cyc], "dqValid", int'(dqValid), int'(expValid[cyc]));
      check(dqData == expData[cyc], expTag[cyc], "dqData", int'(dqData), int'(expData[cyc]));
      check(modeErr == modeBad(benchMode), "R8 modeErr", "modeErr", int'(modeErr),
            int'(modeBad(benchMode)));
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      fails++;
      $display("FAIL R5 watchdog expired at cycle %0d: got hung expected done", wd);
      summary();
      $finish;
    end
  end

  task automatic cmd(input bit ld, input logic [6:0] mw, input bit rd, input logic [7:0] col);
    modeLoad = ld; modeWord = mw; readCmd = rd; readCol = col;
    @(negedge clk);
    modeLoad = 0; readCmd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 0;
    repeat (3) @(negedge clk);
    check(dqOe == 0, "R1", "reset dqOe", int'(dqOe), 0);
    check(dqValid == 0, "R1", "reset dqValid", int'(dqValid), 0);
    check(dqData == 0, "R1", "reset dqData", int'(dqData), 0);
    check(modeErr == 0, "R1", "reset modeErr", int'(modeErr), 0);
    rstN = 1;
    running = 1;

    scen = "R1 R2 default";
    cmd(0, 7'h00, 1, 8'h35); idle(5);

    scen = "R2 R6";
    cmd(1, 7'h32, 0, 8'h00); cmd(0, 7'h00, 1, 8'h1E); idle(8);

    scen = "R2 R7";
    cmd(1, 7'h2B, 0, 8'h00); cmd(0, 7'h00, 1, 8'h5B); idle(12);

    scen = "R7 cl3";
    cmd(1, 7'h3B, 0, 8'h00); cmd(0, 7'h00, 1, 8'hC4); idle(12);

    scen = "R2 bl2";
    cmd(1, 7'h21, 0, 8'h00); cmd(0, 7'h00, 1, 8'h7F); idle(5);

    scen = "R8";
    cmd(1, 7'h24, 0, 8'h00); cmd(0, 7'h00, 1, 8'h10); idle(6);
    cmd(1, 7'h12, 0, 8'h00); cmd(0, 7'h00, 1, 8'h20); idle(6);
    cmd(1, 7'h33, 0, 8'h00); cmd(0, 7'h00, 1, 8'h48); cmd(1, 7'h24, 0, 8'h00);
    cmd(0, 7'h00, 1, 8'h11); idle(12);

    scen = "R9";
    cmd(1, 7'h33, 0, 8'h00); cmd(0, 7'h00, 1, 8'h40); idle(3);
    cmd(0, 7'h00, 1, 8'h85); idle(14);
    cmd(1, 7'h2A, 0, 8'h00);
    for (int k = 0; k < 5; k++) cmd(0, 7'h00, 1, 8'(8'h90 + k * 3));
    idle(10);
    cmd(1, 7'h33, 0, 8'h00); cmd(0, 7'h00, 1, 8'hA0); cmd(1, 7'h2A, 0, 8'h00);
    cmd(0, 7'h00, 1, 8'hB5); idle(12);
    cmd(1, 7'h33, 0, 8'h00); cmd(1, 7'h2A, 1, 8'hC0); cmd(0, 7'h00, 1, 8'hD3); idle(12);

    scen = "R11";
    cmd(1, 7'h33, 0, 8'h00); cmd(0, 7'h00, 1, 8'h66); cmd(1, 7'h20, 0, 8'h00); idle(14);
    cmd(1, 7'h2B, 0, 8'h00); cmd(1, 7'h31, 1, 8'h0D); idle(14);

    idle(4);
    summary();
    $finish;
  end

endmodule